// File: doc/BRIEF.md
# Indirect Video Word Memory Port

This block lets a host processor reach a word-organised video memory that lies outside the processor's own address map. The host sees three 16-bit registers: a pointer, a data window and a signed step. A write to the data window stores the word at the pointer's address and then moves the pointer by the step. A read of the data window returns the word that was fetched when the pointer was last loaded.

Storage is split into two zones, selected by pointer bit 15. The lower zone holds `2**LO_AW` words and the upper zone holds `2**UP_AW` words. Address bits above a zone's index width are ignored, so higher addresses alias back onto the stored words. The step adder is only 15 bits wide. The pointer therefore wraps inside its own zone, and moving to the other zone takes an explicit pointer write.

A timing monitor measures three minimum spacings: between data writes, from a data write to a pointer change, and from a pointer change to a data read. Any access that comes too early sets a sticky flag and a code, and the access is still carried out. Memory access is allowed at any time. No display-phase interlock is applied.

Top module: `vmem_access_port`

## Requirements
- R1: `host_offs` selects the register. Offset 0 is the pointer, offset 2 is the data window and offset 4 is the step. An access at any other offset changes no state and reads back 0. Reads at offset 0 return the pointer, and reads at offset 4 return the step.
- R2: A write at offset 2 stores `host_wdata` at the current pointer. It then sets pointer bits 14:0 to their old value plus step bits 14:0, modulo 2^15.
- R3: A data-window write never changes pointer bit 15. A pointer at 0x0000 with step 0xFFFF becomes 0x7FFF, and a pointer at 0x8000 with the same step becomes 0xFFFF.
- R4: A pointer write fetches the word at the new address. A data-window read returns that word, even when the read comes in the very next cycle, and the read leaves the pointer unchanged.
- R5: Pointer bit 15 picks the zone (0 lower, 1 upper). Within a zone, only the low `LO_AW` or `UP_AW` bits index the storage. With the defaults, 0x0400 aliases 0x0000 and 0x8800 aliases 0x8000.
- R6: A data write that comes fewer than `WW_GAP` (12) cycles after the previous data write is a violation with code 1. A spacing of exactly 12 is legal.
- R7: A pointer write that comes fewer than `WA_GAP` (16) cycles after the last data write is a violation with code 2. A spacing of exactly 16 is legal.
- R8: A data read that comes fewer than `AR_GAP` (16) cycles after the last pointer write is a violation with code 3. A spacing of exactly 16 is legal.
- R9: `viol_flag` stays set until reset. `viol_code` shows the code of the most recent violation. A violating access is still carried out.
- R10: `host_ready` is high for exactly the one cycle that follows each accepted access. `host_rdata` is valid in that same cycle.
- R11: After reset, the pointer and the step are 0, and `host_ready`, `viol_flag` and `viol_code` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Access request, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_offs | input | 3 | Register offset (0, 2 or 4) |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid while `host_ready` is high |
| host_ready | output | 1 | Access completion pulse |
| viol_flag | output | 1 | Sticky timing-violation flag |
| viol_code | output | 2 | Code of the latest violation: 1 write-write, 2 write-pointer, 3 pointer-read |

## Verification
A data read can land in the cycle right after a pointer write, so it falls in the same cycle as the completion of that write's fetch. The bench provokes this by issuing the read back-to-back with the pointer write. It then checks two things: the returned word must come from the new address, through the bypass rather than the stale fetch register, and a pointer-read violation must be raised in the same cycle. Likewise, a violating data write both stores its word and raises the flag at one edge, and the bench reads the word back later.

// File: rtl/vmp_pkg.sv
package vmp_pkg;
   typedef enum logic [1:0] {
      VIOL_NONE = 2'd0,
      VIOL_WW   = 2'd1,
      VIOL_WA   = 2'd2,
      VIOL_AR   = 2'd3
   } viol_e;

   localparam logic [2:0] OFFS_PTR  = 3'd0;
   localparam logic [2:0] OFFS_DATA = 3'd2;
   localparam logic [2:0] OFFS_STEP = 3'd4;

   typedef struct packed {
      logic ptr_wr;
      logic ptr_rd;
      logic data_wr;
      logic data_rd;
      logic step_wr;
      logic step_rd;
   } acc_s;
endpackage

// File: rtl/vmp_decode.sv
module vmp_decode
   import vmp_pkg::*;
(
   input  logic       sel,
   input  logic       we,
   input  logic [2:0] offs,
   output acc_s       acc
);
   always_comb begin
      acc         = '0;
      acc.ptr_wr  = sel &&  we && (offs == OFFS_PTR);
      acc.ptr_rd  = sel && !we && (offs == OFFS_PTR);
      acc.data_wr = sel &&  we && (offs == OFFS_DATA);
      acc.data_rd = sel && !we && (offs == OFFS_DATA);
      acc.step_wr = sel &&  we && (offs == OFFS_STEP);
      acc.step_rd = sel && !we && (offs == OFFS_STEP);
   end
endmodule

// File: rtl/vmp_pointer.sv
module vmp_pointer #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ptr_wr,
   input  logic          data_wr,
   input  logic          step_wr,
   input  logic [AW-1:0] wdata,
   output logic [AW-1:0] ptr,
   output logic [AW-1:0] step
);
   localparam int LOW_W = AW - 1;

   if (AW < 2) begin : g_bad_aw
      $error("vmp_pointer: AW must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr  <= '0;
         step <= '0;
      end else begin
         if (ptr_wr)
            ptr <= wdata;
         else if (data_wr)
            ptr <= {ptr[AW-1], ptr[LOW_W-1:0] + step[LOW_W-1:0]};
         if (step_wr)
            step <= wdata;
      end
   end

   // R3: the zone bit survives every post-write step
   a_r3_zone_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !ptr_wr) |=> (ptr[AW-1] == $past(ptr[AW-1])));
endmodule

// File: rtl/vmp_store.sv
module vmp_store #(
   parameter int DW    = 16,
   parameter int LO_AW = 10,
   parameter int UP_AW = 11
) (
   input  logic             clk,
   input  logic             we,
   input  logic             zone,
   input  logic [LO_AW-1:0] lo_idx,
   input  logic [UP_AW-1:0] up_idx,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata
);
   localparam int LO_WORDS = 1 << LO_AW;
   localparam int UP_WORDS = 1 << UP_AW;

   if (LO_AW < 1 || LO_AW > 15 || UP_AW < 1 || UP_AW > 15) begin : g_bad_idx
      $error("vmp_store: zone index widths must lie in 1..15");
   end

   logic [DW-1:0] lo_mem [LO_WORDS];
   logic [DW-1:0] up_mem [UP_WORDS];

   always_ff @(posedge clk) begin
      if (we && !zone) lo_mem[lo_idx] <= wdata;
      if (we &&  zone) up_mem[up_idx] <= wdata;
   end

   assign rdata = zone ? up_mem[up_idx] : lo_mem[lo_idx];
endmodule

// File: rtl/vmp_gapchk.sv
module vmp_gapchk
   import vmp_pkg::*;
#(
   parameter int WW_GAP = 12,
   parameter int WA_GAP = 16,
   parameter int AR_GAP = 16
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  data_wr,
   input  logic  ptr_wr,
   input  logic  data_rd,
   output logic  viol_flag,
   output viol_e viol_code
);
   localparam int MAX_A   = (WW_GAP > WA_GAP) ? WW_GAP : WA_GAP;
   localparam int MAX_GAP = (MAX_A > AR_GAP) ? MAX_A : AR_GAP;
   localparam int CNT_W   = $clog2(MAX_GAP + 1);
   localparam logic [CNT_W-1:0] LIM = CNT_W'(MAX_GAP);

   if (WW_GAP < 1 || WA_GAP < 1 || AR_GAP < 1) begin : g_bad_gap
      $error("vmp_gapchk: every gap must be at least 1");
   end

   logic [CNT_W-1:0] since_w, since_a;
   logic             seen_w, seen_a;
   logic             hit_ww, hit_wa, hit_ar;

   always_comb begin
      hit_ww = data_wr && seen_w && (since_w < CNT_W'(WW_GAP));
      hit_wa = ptr_wr  && seen_w && (since_w < CNT_W'(WA_GAP));
      hit_ar = data_rd && seen_a && (since_a < CNT_W'(AR_GAP));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_w   <= '0;
         since_a   <= '0;
         seen_w    <= 1'b0;
         seen_a    <= 1'b0;
         viol_flag <= 1'b0;
         viol_code <= VIOL_NONE;
      end else begin
         if (data_wr) begin
            since_w <= CNT_W'(1);
            seen_w  <= 1'b1;
         end else if (since_w != LIM) begin
            since_w <= since_w + 1'b1;
         end
         if (ptr_wr) begin
            since_a <= CNT_W'(1);
            seen_a  <= 1'b1;
         end else if (since_a != LIM) begin
            since_a <= since_a + 1'b1;
         end
         if (hit_ww || hit_wa || hit_ar)
            viol_flag <= 1'b1;
         if (hit_ww)      viol_code <= VIOL_WW;
         else if (hit_wa) viol_code <= VIOL_WA;
         else if (hit_ar) viol_code <= VIOL_AR;
      end
   end

   // R9: once raised the flag stays until reset
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      viol_flag |=> viol_flag);
   // R6: back-to-back data writes always report a write-write violation
   a_r6_b2b_write: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && $past(data_wr) && $past(rst_n)) |=> (viol_code == VIOL_WW));
   // R8: a read right after a pointer write always reports pointer-read
   a_r8_b2b_read: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && $past(ptr_wr) && $past(rst_n)) |=> (viol_code == VIOL_AR));
endmodule

// File: rtl/vmem_access_port.sv
module vmem_access_port
   import vmp_pkg::*;
#(
   parameter int DW     = 16,
   parameter int LO_AW  = 10,
   parameter int UP_AW  = 11,
   parameter int WW_GAP = 12,
   parameter int WA_GAP = 16,
   parameter int AR_GAP = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_sel,
   input  logic          host_we,
   input  logic [2:0]    host_offs,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata,
   output logic          host_ready,
   output logic          viol_flag,
   output logic [1:0]    viol_code
);
   localparam int AW = DW;

   if (DW != 16) begin : g_bad_dw
      $error("vmem_access_port: the word and pointer width must be 16");
   end

   acc_s          acc;
   logic [AW-1:0] ptr, step;
   logic [DW-1:0] mem_rd, pf_word;
   logic          pf_pending;
   viol_e         code_e;

   vmp_decode u_decode (
      .sel  (host_sel),
      .we   (host_we),
      .offs (host_offs),
      .acc  (acc)
   );

   vmp_pointer #(.AW(AW)) u_pointer (
      .clk     (clk),
      .rst_n   (rst_n),
      .ptr_wr  (acc.ptr_wr),
      .data_wr (acc.data_wr),
      .step_wr (acc.step_wr),
      .wdata   (host_wdata),
      .ptr     (ptr),
      .step    (step)
   );

   vmp_store #(.DW(DW), .LO_AW(LO_AW), .UP_AW(UP_AW)) u_store (
      .clk    (clk),
      .we     (acc.data_wr),
      .zone   (ptr[AW-1]),
      .lo_idx (ptr[LO_AW-1:0]),
      .up_idx (ptr[UP_AW-1:0]),
      .wdata  (host_wdata),
      .rdata  (mem_rd)
   );

   vmp_gapchk #(.WW_GAP(WW_GAP), .WA_GAP(WA_GAP), .AR_GAP(AR_GAP)) u_gapchk (
      .clk       (clk),
      .rst_n     (rst_n),
      .data_wr   (acc.data_wr),
      .ptr_wr    (acc.ptr_wr),
      .data_rd   (acc.data_rd),
      .viol_flag (viol_flag),
      .viol_code (code_e)
   );

   assign viol_code = code_e;

   // fetch after a pointer load
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pf_pending <= 1'b0;
         pf_word    <= '0;
      end else begin
         pf_pending <= acc.ptr_wr;
         if (pf_pending)
            pf_word <= mem_rd;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_ready <= 1'b0;
         host_rdata <= '0;
      end else begin
         host_ready <= host_sel;
         if (acc.ptr_rd)
            host_rdata <= ptr;
         else if (acc.data_rd)
            host_rdata <= pf_pending ? mem_rd : pf_word;
         else if (acc.step_rd)
            host_rdata <= step;
         else if (host_sel && !host_we)
            host_rdata <= '0;
      end
   end

   // R4: a data-window read never moves the pointer
   a_r4_read_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      acc.data_rd |=> $stable(ptr));
   // R1: without an access the pointer and step hold
   a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !host_sel |=> ($stable(ptr) && $stable(step)));
endmodule

// File: tb/vmem_access_port_tb.sv
`timescale 1ns/1ps
module vmem_access_port_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_sel = 1'b0;
   logic        host_we = 1'b0;
   logic [2:0]  host_offs = 3'd0;
   logic [15:0] host_wdata = 16'h0;
   logic [15:0] host_rdata;
   logic        host_ready;
   logic        viol_flag;
   logic [1:0]  viol_code;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   vmem_access_port u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_sel   (host_sel),
      .host_we    (host_we),
      .host_offs  (host_offs),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .host_ready (host_ready),
      .viol_flag  (viol_flag),
      .viol_code  (viol_code)
   );

   typedef struct packed {
      logic [2:0]  offs;
      logic        we;
      logic [15:0] wd;
      logic        chk;
      logic [15:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NVEC = 25;
   localparam vec_t VEC [NVEC] = '{
      '{3'd0, 1'b1, 16'h0010, 1'b0, 16'h0000, 4'd1},
      '{3'd4, 1'b1, 16'h0001, 1'b0, 16'h0000, 4'd1},
      '{3'd2, 1'b1, 16'hA001, 1'b0, 16'h0000, 4'd2},
      '{3'd2, 1'b1, 16'hA002, 1'b0, 16'h0000, 4'd2},
      '{3'd0, 1'b0, 16'h0000, 1'b1, 16'h0012, 4'd2},  // R2 pointer stepped twice
      '{3'd0, 1'b1, 16'h0010, 1'b0, 16'h0000, 4'd4},
      '{3'd2, 1'b0, 16'h0000, 1'b1, 16'hA001, 4'd4},  // R4 fetched word
      '{3'd2, 1'b0, 16'h0000, 1'b1, 16'hA001, 4'd4},  // R4 repeat read
      '{3'd0, 1'b0, 16'h0000, 1'b1, 16'h0010, 4'd4},  // R4 pointer unmoved
      '{3'd4, 1'b1, 16'hFFFF, 1'b0, 16'h0000, 4'd3},
      '{3'd0, 1'b1, 16'h0000, 1'b0, 16'h0000, 4'd3},
      '{3'd2, 1'b1, 16'hB000, 1'b0, 16'h0000, 4'd3},
      '{3'd0, 1'b0, 16'h0000, 1'b1, 16'h7FFF, 4'd3},  // R3 lower wrap
      '{3'd0, 1'b1, 16'h8000, 1'b0, 16'h0000, 4'd3},
      '{3'd2, 1'b1, 16'hC000, 1'b0, 16'h0000, 4'd3},
      '{3'd0, 1'b0, 16'h0000, 1'b1, 16'hFFFF, 4'd3},  // R3 upper wrap
      '{3'd0, 1'b1, 16'h8800, 1'b0, 16'h0000, 4'd5},
      '{3'd2, 1'b0, 16'h0000, 1'b1, 16'hC000, 4'd5},  // R5 upper alias
      '{3'd0, 1'b1, 16'h0400, 1'b0, 16'h0000, 4'd5},
      '{3'd2, 1'b0, 16'h0000, 1'b1, 16'hB000, 4'd5},  // R5 lower alias
      '{3'd6, 1'b1, 16'h1234, 1'b0, 16'h0000, 4'd1},
      '{3'd0, 1'b0, 16'h0000, 1'b1, 16'h0400, 4'd1},  // R1 odd offset ignored
      '{3'd4, 1'b0, 16'h0000, 1'b1, 16'hFFFF, 4'd1},  // R1 step readback
      '{3'd0, 1'b1, 16'h0011, 1'b0, 16'h0000, 4'd5},
      '{3'd2, 1'b0, 16'h0000, 1'b1, 16'hA002, 4'd5}   // R5 lower word kept
   };

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      host_sel = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // one access; returns read data after its completion edge
   task automatic acc(input logic [2:0] offs, input logic we, input logic [15:0] wd,
                      output logic [15:0] rd);
      @(negedge clk);
      host_sel = 1'b1; host_we = we; host_offs = offs; host_wdata = wd;
      @(negedge clk);
      host_sel = 1'b0;
      rd = host_rdata;
      check("R10 ready", {15'd0, host_ready}, 16'd1);
   endtask

   // wait so the next acc lands g cycles after the previous one
   task automatic gap(input int g);
      repeat (g - 2) @(negedge clk);
   endtask

   task automatic ptr_then_read(input logic [15:0] a, output logic [15:0] rd);
      @(negedge clk);
      host_sel = 1'b1; host_we = 1'b1; host_offs = 3'd0; host_wdata = a;
      @(negedge clk);
      host_we = 1'b0; host_offs = 3'd2;
      @(negedge clk);
      host_sel = 1'b0;
      rd = host_rdata;
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] rd;
      do_reset();
      // R11 reset state
      check("R11 ready", {15'd0, host_ready}, 16'd0);
      check("R11 flag", {15'd0, viol_flag}, 16'd0);
      check("R11 code", {14'd0, viol_code}, 16'd0);
      acc(3'd0, 1'b0, 16'h0, rd); check("R11 pointer", rd, 16'h0000);
      gap(17);
      acc(3'd4, 1'b0, 16'h0, rd); check("R11 step", rd, 16'h0000);
      @(negedge clk);
      check("R10 ready drops", {15'd0, host_ready}, 16'd0);

      for (int i = 0; i < NVEC; i++) begin
         gap(17);
         acc(VEC[i].offs, VEC[i].we, VEC[i].wd, rd);
         if (VEC[i].chk) begin
            checks++;
            if (rd !== VEC[i].exp) begin
               errors++;
               $display("FAIL R%0d vector %0d: actual %h expected %h",
                        VEC[i].req, i, rd, VEC[i].exp);
            end
         end
      end
      check("R6 R7 R8 no flag at legal spacing", {15'd0, viol_flag}, 16'd0);

      // R6 write-write spacing
      do_reset();
      acc(3'd0, 1'b1, 16'h0020, rd); gap(17);
      acc(3'd4, 1'b1, 16'h0001, rd); gap(17);
      acc(3'd2, 1'b1, 16'h1111, rd); gap(12);
      acc(3'd2, 1'b1, 16'h2222, rd);
      check("R6 gap 12 legal", {15'd0, viol_flag}, 16'd0);
      gap(11);
      acc(3'd2, 1'b1, 16'h3333, rd);
      check("R6 gap 11 flag", {15'd0, viol_flag}, 16'd1);
      check("R6 gap 11 code", {14'd0, viol_code}, 16'd1);
      gap(17);
      acc(3'd0, 1'b1, 16'h0022, rd); gap(17);
      acc(3'd2, 1'b0, 16'h0, rd);
      check("R9 violating write performed", rd, 16'h3333);
      check("R9 code held", {14'd0, viol_code}, 16'd1);

      // R7 write-to-pointer spacing
      do_reset();
      acc(3'd0, 1'b1, 16'h0030, rd); gap(17);
      acc(3'd2, 1'b1, 16'h4444, rd); gap(16);
      acc(3'd0, 1'b1, 16'h0030, rd);
      check("R7 gap 16 legal", {15'd0, viol_flag}, 16'd0);
      gap(17);
      acc(3'd2, 1'b1, 16'h5555, rd); gap(15);
      acc(3'd0, 1'b1, 16'h0030, rd);
      check("R7 gap 15 flag", {15'd0, viol_flag}, 16'd1);
      check("R7 gap 15 code", {14'd0, viol_code}, 16'd2);

      // R8 pointer-to-read spacing
      do_reset();
      acc(3'd0, 1'b1, 16'h0010, rd); gap(16);
      acc(3'd2, 1'b0, 16'h0, rd);
      check("R8 gap 16 data", rd, 16'hA001);
      check("R8 gap 16 legal", {15'd0, viol_flag}, 16'd0);
      gap(17);
      acc(3'd0, 1'b1, 16'h0011, rd); gap(15);
      acc(3'd2, 1'b0, 16'h0, rd);
      check("R8 gap 15 data", rd, 16'hA002);
      check("R8 gap 15 code", {14'd0, viol_code}, 16'd3);
      gap(17);
      ptr_then_read(16'h0010, rd);
      check("R4 next-cycle read bypass", rd, 16'hA001);
      check("R8 next-cycle read flag", {15'd0, viol_flag}, 16'd1);

      // R9 code follows the latest violation
      gap(17);
      acc(3'd2, 1'b1, 16'h6666, rd); gap(3);
      acc(3'd2, 1'b1, 16'h7777, rd);
      check("R9 latest code", {14'd0, viol_code}, 16'd1);
      check("R9 flag sticky", {15'd0, viol_flag}, 16'd1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule